// File: doc/BRIEF.md
# Conditional Sum Adder

This block is a purely combinational binary adder of parameterized width, where the width is a power of two (16 by default). It adds two unsigned operands and a carry input. It returns the sum and a carry output. There is no clock, no register and no handshake, so the result follows the inputs after the combinational delay.

Carries are not passed along from bit to bit, and no lookahead network is used. Each bit position first forms two candidate sum/carry pairs: one assumes an incoming carry of 0 and the other assumes an incoming carry of 1. Neither pair waits on the real carry. A tree of log2(WIDTH) merge levels then joins neighbouring sections into sections twice as wide. At each join, the lower section's candidate carries choose which candidate of the upper section is kept for each assumption. At the end, two whole-width candidates remain, and the external carry input picks one of them.

The datapath uses no arithmetic operator. It is built only from per-bit gates and two-way multiplexers that generate loops lay out.

Top module: `cond_sum_adder`

## Requirements
- R1: The `sum` output equals the low WIDTH bits of a + b + cin for every input combination.
- R2: `cout` is 1 exactly when a + b + cin is 2^WIDTH or greater.
- R3: At WIDTH = 4, all 512 combinations of a, b and cin produce the correct {cout, sum}.
- R4: With cin = 0, the outputs equal the whole-width candidate formed under the zero-carry assumption, which is a + b.
- R5: With cin = 1, the outputs equal the whole-width candidate formed under the one-carry assumption, which is a + b + 1.
- R6: Operands of all ones with cin = 1 give sum equal to all ones and cout = 1. Operands of all ones with cin = 0 give sum equal to all ones except bit 0 clear, and cout = 1.
- R7: Zero plus zero gives sum 0 and cout 0 with cin = 0, and gives sum 1 and cout 0 with cin = 1.
- R8: Alternating operands (bit i of a set for odd i, bit i of b set for even i) give sum all ones and cout 0 with cin = 0. With cin = 1 the same operands give sum 0 and cout 1, because the carry crosses every bit.
- R9: When only the most significant bit is set in both operands, a carry is generated at the top bit alone: sum equals cin in bit 0 and zero elsewhere, and cout = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand, unsigned |
| b | input | WIDTH | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the total |
| cout | output | 1 | Carry out of the top bit |

## Verification
At width 4, every operand pair is tried with both carry values. This covers each conditional-cell case and each merge-select combination at every level of the tree. At width 16, a large random set shows that the merge trees scale. Directed patterns then aim at specific paths. The alternating patterns make every bit propagate, so the one-carry candidate has to win at every level of the tree. Top-bit-only operands generate a carry at a single position, and all-ones and all-zeros operands test the two extremes, so a wrong select polarity at any level shows up as a wrong sum or carry.

// File: rtl/csa_pkg.sv
package csa_pkg;

  typedef struct packed {
    logic s0;
    logic c0;
    logic s1;
    logic c1;
  } cell_pair_t;

  // Candidate pairs for one bit; the real incoming carry is not an input.
  function automatic cell_pair_t cond_cell(input logic a_bit, input logic b_bit);
    cell_pair_t r;
    r.s0 = a_bit ^ b_bit;
    r.c0 = a_bit & b_bit;
    r.s1 = ~(a_bit ^ b_bit);
    r.c1 = a_bit | b_bit;
    return r;
  endfunction

  // Two-way choice steered by a carry line.
  function automatic logic carry_pick(input logic sel, input logic when0, input logic when1);
    return sel ? when1 : when0;
  endfunction

endpackage

// File: rtl/csa_cell.sv
module csa_cell
  import csa_pkg::*;
(
  input  logic a_bit,
  input  logic b_bit,
  output logic s0,
  output logic c0,
  output logic s1,
  output logic c1
);
  cell_pair_t pair;

  assign pair = cond_cell(a_bit, b_bit);
  assign s0 = pair.s0;
  assign c0 = pair.c0;
  assign s1 = pair.s1;
  assign c1 = pair.c1;
endmodule

// File: rtl/csa_merge.sv
module csa_merge
  import csa_pkg::*;
#(
  parameter int HALF = 1
) (
  input  logic [HALF-1:0]   lo_s0,
  input  logic [HALF-1:0]   lo_s1,
  input  logic              lo_c0,
  input  logic              lo_c1,
  input  logic [HALF-1:0]   hi_s0,
  input  logic [HALF-1:0]   hi_s1,
  input  logic              hi_c0,
  input  logic              hi_c1,
  output logic [2*HALF-1:0] m_s0,
  output logic [2*HALF-1:0] m_s1,
  output logic              m_c0,
  output logic              m_c1
);
  for (genvar i = 0; i < HALF; i++) begin : g_bit
    assign m_s0[i]        = lo_s0[i];
    assign m_s1[i]        = lo_s1[i];
    assign m_s0[HALF + i] = carry_pick(lo_c0, hi_s0[i], hi_s1[i]);
    assign m_s1[HALF + i] = carry_pick(lo_c1, hi_s0[i], hi_s1[i]);
  end

  assign m_c0 = carry_pick(lo_c0, hi_c0, hi_c1);
  assign m_c1 = carry_pick(lo_c1, hi_c0, hi_c1);
endmodule

// File: rtl/csa_final_sel.sv
module csa_final_sel
  import csa_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             cin,
  input  logic [WIDTH-1:0] cand_s0,
  input  logic [WIDTH-1:0] cand_s1,
  input  logic             cand_c0,
  input  logic             cand_c1,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum[i] = carry_pick(cin, cand_s0[i], cand_s1[i]);
  end
  assign cout = carry_pick(cin, cand_c0, cand_c1);
endmodule

// File: rtl/cond_sum_adder.sv
module cond_sum_adder #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int LEVELS = $clog2(WIDTH);

  // Whole-width candidates, brought out by name for the checker.
  logic [WIDTH-1:0] whole_s0;
  logic [WIDTH-1:0] whole_s1;
  logic             whole_c0;
  logic             whole_c1;

  for (genvar l = 0; l <= LEVELS; l++) begin : lvl
    localparam int SECS = WIDTH >> l;
    localparam int SPAN = 1 << l;
    logic [WIDTH-1:0] s0;
    logic [WIDTH-1:0] s1;
    logic [SECS-1:0]  c0;
    logic [SECS-1:0]  c1;

    if (l == 0) begin : g_cells
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        csa_cell u_cell (
          .a_bit (a[i]),
          .b_bit (b[i]),
          .s0    (s0[i]),
          .c0    (c0[i]),
          .s1    (s1[i]),
          .c1    (c1[i])
        );
      end
    end else begin : g_merge
      localparam int HALF = SPAN / 2;
      for (genvar g = 0; g < SECS; g++) begin : g_sec
        csa_merge #(.HALF(HALF)) u_merge (
          .lo_s0 (lvl[l-1].s0[(2*g)*HALF +: HALF]),
          .lo_s1 (lvl[l-1].s1[(2*g)*HALF +: HALF]),
          .lo_c0 (lvl[l-1].c0[2*g]),
          .lo_c1 (lvl[l-1].c1[2*g]),
          .hi_s0 (lvl[l-1].s0[(2*g+1)*HALF +: HALF]),
          .hi_s1 (lvl[l-1].s1[(2*g+1)*HALF +: HALF]),
          .hi_c0 (lvl[l-1].c0[2*g+1]),
          .hi_c1 (lvl[l-1].c1[2*g+1]),
          .m_s0  (s0[g*SPAN +: SPAN]),
          .m_s1  (s1[g*SPAN +: SPAN]),
          .m_c0  (c0[g]),
          .m_c1  (c1[g])
        );
      end
    end
  end

  assign whole_s0 = lvl[LEVELS].s0;
  assign whole_s1 = lvl[LEVELS].s1;
  assign whole_c0 = lvl[LEVELS].c0[0];
  assign whole_c1 = lvl[LEVELS].c1[0];

  csa_final_sel #(.WIDTH(WIDTH)) u_final (
    .cin     (cin),
    .cand_s0 (whole_s0),
    .cand_s1 (whole_s1),
    .cand_c0 (whole_c0),
    .cand_c1 (whole_c1),
    .sum     (sum),
    .cout    (cout)
  );
endmodule

// File: rtl/cond_sum_adder_checker.sv
module cond_sum_adder_checker #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [WIDTH-1:0] whole_s0,
  input logic [WIDTH-1:0] whole_s1,
  input logic             whole_c0,
  input logic             whole_c1
);
  logic [WIDTH:0] ref_total;
  logic [WIDTH:0] ref_plain;
  logic [WIDTH:0] ref_plus1;
  logic           known;

  always_comb begin
    ref_plain = {1'b0, a} + {1'b0, b};
    ref_plus1 = ref_plain + 1'b1;
    ref_total = cin ? ref_plus1 : ref_plain;
    known     = !$isunknown({a, b, cin});
  end

  always_comb begin
    if (known) begin
      assert_sum_R1: assert (sum == ref_total[WIDTH-1:0]);
      assert_cout_R2: assert (cout == ref_total[WIDTH]);
      assert_zero_cand_R4: assert ({whole_c0, whole_s0} == ref_plain);
      assert_one_cand_R5: assert ({whole_c1, whole_s1} == ref_plus1);
      if (cin) begin
        assert_pick_one_R5: assert ({cout, sum} == {whole_c1, whole_s1});
      end else begin
        assert_pick_zero_R4: assert ({cout, sum} == {whole_c0, whole_s0});
      end
      if ((&a) && (&b) && cin) begin
        assert_all_ones_R6: assert (cout && (&sum));
      end
    end
  end
endmodule

bind cond_sum_adder cond_sum_adder_checker #(.WIDTH(WIDTH)) u_checker (
  .a        (a),
  .b        (b),
  .cin      (cin),
  .sum      (sum),
  .cout     (cout),
  .whole_s0 (whole_s0),
  .whole_s1 (whole_s1),
  .whole_c0 (whole_c0),
  .whole_c1 (whole_c1)
);

// File: tb/cond_sum_adder_test.sv
module cond_sum_adder_test;
  localparam int W  = 16;
  localparam int W4 = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0]  a16 = '0, b16 = '0, s16;
  logic          ci16 = 1'b0, co16;
  logic [W4-1:0] a4 = '0, b4 = '0, s4;
  logic          ci4 = 1'b0, co4;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  cond_sum_adder #(.WIDTH(W)) uut (
    .a(a16), .b(b16), .cin(ci16), .sum(s16), .cout(co16)
  );

  cond_sum_adder #(.WIDTH(W4)) uut_w4 (
    .a(a4), .b(b4), .cin(ci4), .sum(s4), .cout(co4)
  );

  task automatic compare(input string req, input logic [W:0] act, input logic [W:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply16(input string req, input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic c, input logic [W:0] exp);
    @(negedge clk);
    a16 = x; b16 = y; ci16 = c;
    #4;
    compare(req, {co16, s16}, exp);
  endtask

  function automatic logic [W:0] golden16(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic c);
    logic [W:0] t;
    t = {1'b0, x} + {1'b0, y};
    t = t + {{W{1'b0}}, c};
    return t;
  endfunction

  task automatic test_reset_state();
    @(negedge clk);
    #4;
    compare("R7 idle zero inputs", {co16, s16}, '0);
  endtask

  task automatic test_exhaustive_w4();
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        for (int c = 0; c < 2; c++) begin
          @(negedge clk);
          a4 = x[3:0]; b4 = y[3:0]; ci4 = c[0];
          #4;
          compare("R3 width4", {{(W-W4){1'b0}}, co4, s4},
                  W'(x + y + c));
        end
      end
    end
  endtask

  task automatic test_random_w16();
    for (int n = 0; n < 2000; n++) begin
      logic [W-1:0] x, y;
      logic c;
      x = W'($urandom);
      y = W'($urandom);
      c = 1'($urandom);
      apply16(c ? "R1 R2 R5 random" : "R1 R2 R4 random", x, y, c, golden16(x, y, c));
    end
  endtask

  task automatic test_candidates();
    apply16("R4 cin0", 16'h1234, 16'h4321, 1'b0, 17'h05555);
    apply16("R5 cin1", 16'h1234, 16'h4321, 1'b1, 17'h05556);
    apply16("R2 carry exact", 16'hFFFF, 16'h0001, 1'b0, 17'h10000);
    apply16("R2 no carry edge", 16'hFFFE, 16'h0001, 1'b0, 17'h0FFFF);
  endtask

  task automatic test_corners();
    apply16("R6 all ones cin1", 16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF);
    apply16("R6 all ones cin0", 16'hFFFF, 16'hFFFF, 1'b0, 17'h1FFFE);
    apply16("R7 zero cin0", 16'h0000, 16'h0000, 1'b0, 17'h00000);
    apply16("R7 zero cin1", 16'h0000, 16'h0000, 1'b1, 17'h00001);
    apply16("R8 alternate cin0", 16'hAAAA, 16'h5555, 1'b0, 17'h0FFFF);
    apply16("R8 alternate cin1", 16'hAAAA, 16'h5555, 1'b1, 17'h10000);
    apply16("R8 alternate swap", 16'h5555, 16'hAAAA, 1'b1, 17'h10000);
    apply16("R9 msb only cin0", 16'h8000, 16'h8000, 1'b0, 17'h10000);
    apply16("R9 msb only cin1", 16'h8000, 16'h8000, 1'b1, 17'h10001);
    apply16("R1 same alternate", 16'hAAAA, 16'hAAAA, 1'b0, 17'h15554);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    test_reset_state();
    test_candidates();
    test_corners();
    test_exhaustive_w4();
    test_random_w16();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule